// File: doc/BRIEF.md
# Write-Masked Configuration Register Bank

This block is a small bank of 32-bit control registers behind a single-cycle write port and a combinational read port. Every write word carries its own per-bit enable: the upper sixteen bits select which of the lower sixteen bits take the new value. Software can therefore change any group of bits in one access, with no read-modify-write sequence.

One register, the configuration word, drives a narrow write channel into a PHY-side store of 64 entries, each 4 bits wide. Software first loads a 4-bit data field and a 6-bit address field. It then raises the strobe bit. Only the 0-to-1 transition of that bit commits a write, so setting the strobe again while it is already 1 is harmless. A second register holds one idle-control bit per lane, and a read-only word reports two PLL status inputs.

Top module: `wmask_cfg_bank`

## Requirements
- R1: On a write to a storing register (index 0 or 1), stored bit x takes written bit x exactly when written bit x+16 is 1; bits whose enable is 0 keep their value.
- R2: A read returns 0 in bits 31:16 and the stored or reported value in bits 15:0; index 3 reads as all zero.
- R3: When bit 0 (strobe) of the configuration register (index 0) goes from 0 to 1, `phy_cfg_we` is high for exactly one cycle, the cycle that follows the write. Writing 1 to a strobe that is already 1 gives no pulse.
- R4: A commit writes the data field (configuration bits 10:7) into the store entry selected by the address field (configuration bits 6:1). The new entry is visible on `store_rdata` in the cycle after the pulse.
- R5: Bits 3, 4, 5 and 6 of the lane register (index 1) idle lanes 0, 1, 2 and 3; a 1 idles the lane. They appear on `lane_idle[3:0]`.
- R6: The status word (index 2) shows `pll_locked` at bit 9 and `pll_out_pend` at bit 10, with all other bits zero. Writes to it have no effect.
- R7: After reset the configuration register reads 0, the lane register reads 0x0078 (all four lanes idle), every store entry is 0 and no commit pulse is issued.
- R8: A write whose upper half is all zero changes no register and causes no commit.
- R9: During the commit pulse, `phy_cfg_addr` and `phy_cfg_data` carry the address and data fields of the configuration register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write request, one word per cycle |
| bus_addr | input | 2 | Register index for read and write |
| bus_wdata | input | 32 | Bits 31:16 are the bit enables, bits 15:0 the values |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pll_locked | input | 1 | PLL lock indication, reported in the status word |
| pll_out_pend | input | 1 | PLL output still pending, reported in the status word |
| lane_idle | output | 4 | Idle control, one bit per lane |
| phy_cfg_we | output | 1 | One-cycle commit pulse toward the PHY store |
| phy_cfg_addr | output | 6 | Configuration address field |
| phy_cfg_data | output | 4 | Configuration data field |
| store_raddr | input | 6 | Read index into the PHY configuration store |
| store_rdata | output | 4 | Store entry at `store_raddr` |

## Verification
The assertions check on every cycle that bits without an enable hold their value, that enabled bits load, and that an empty-mask write leaves both registers untouched. They also check that a rising strobe produces a pulse, that a pulse is never longer than one cycle, that a held strobe never commits, and that each committed entry holds its data. Only the bench's scenarios can show the field placement end to end: the three-step load-then-strobe sequence, address and data set in the same write as the strobe, the reset values, the status bit positions, the ignored status writes, and the unused index reading zero.

// File: rtl/wmcb_pkg.sv
package wmcb_pkg;
   // Register indices on the bus
   localparam int REG_CFG  = 0;
   localparam int REG_LANE = 1;
   localparam int REG_STAT = 2;

   // Configuration word layout (decoded by the PHY side)
   localparam int STB_BIT   = 0;
   localparam int CADDR_LSB = 1;

   // Lane register: first idle-control bit
   localparam int LANE_LSB = 3;

   // Status word layout
   localparam int STAT_LOCK_BIT = 9;
   localparam int STAT_PEND_BIT = 10;
endpackage

// File: rtl/wmask_reg.sv
module wmask_reg #(
   parameter int W = 16,
   parameter logic [W-1:0] RESET = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RESET;
      else if (wr_en)
         q <= (q & ~mask) | (wdata & mask);
   end

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask)))); // R1
   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((q & $past(mask)) == ($past(wdata) & $past(mask)))); // R1
endmodule

// File: rtl/cfg_commit.sv
module cfg_commit (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_in,
   output logic commit
);
   logic strobe_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         strobe_prev <= 1'b0;
      else
         strobe_prev <= strobe_in;
   end

   assign commit = strobe_in & ~strobe_prev;

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit); // R3
endmodule

// File: rtl/phy_cfg_store.sv
module phy_cfg_store #(
   parameter int AW = 6,
   parameter int DW = 4,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 2 ** AW;

   logic [DW-1:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];

   AST_STORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (mem[$past(waddr)] == $past(wdata))); // R4
endmodule

// File: rtl/wmask_cfg_bank.sv
module wmask_cfg_bank
   import wmcb_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 2,
   parameter int LANES   = 4,
   parameter int CADDR_W = 6,
   parameter int CDATA_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               pll_locked,
   input  logic               pll_out_pend,
   output logic [LANES-1:0]   lane_idle,
   output logic               phy_cfg_we,
   output logic [CADDR_W-1:0] phy_cfg_addr,
   output logic [CDATA_W-1:0] phy_cfg_data,
   input  logic [CADDR_W-1:0] store_raddr,
   output logic [CDATA_W-1:0] store_rdata
);
   localparam int HALF      = DATA_W / 2;
   localparam int CDATA_LSB = CADDR_LSB + CADDR_W;
   localparam logic [HALF-1:0] LANE_RST =
      HALF'(((1 << LANES) - 1) << LANE_LSB);

   generate
      if (DATA_W % 2 != 0) begin : g_bad_width
         $error("DATA_W must be even");
      end
      if (CDATA_LSB + CDATA_W > HALF) begin : g_bad_cfg
         $error("configuration fields exceed the lower half");
      end
      if (LANE_LSB + LANES > HALF) begin : g_bad_lanes
         $error("lane bits exceed the lower half");
      end
      if (STAT_PEND_BIT >= HALF || (1 << ADDR_W) < 3) begin : g_bad_stat
         $error("status bits or register index out of range");
      end
   endgenerate

   logic            wr_cfg, wr_lane;
   logic [HALF-1:0] cfg_q, lane_q, stat_w;
   logic [HALF-1:0] wr_mask, wr_val;

   assign wr_mask = bus_wdata[DATA_W-1:HALF];
   assign wr_val  = bus_wdata[HALF-1:0];
   assign wr_cfg  = bus_wr && (bus_addr == ADDR_W'(REG_CFG));
   assign wr_lane = bus_wr && (bus_addr == ADDR_W'(REG_LANE));

   wmask_reg #(.W(HALF), .RESET('0)) u_cfg_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_cfg),
      .mask(wr_mask), .wdata(wr_val), .q(cfg_q)
   );

   wmask_reg #(.W(HALF), .RESET(LANE_RST)) u_lane_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_lane),
      .mask(wr_mask), .wdata(wr_val), .q(lane_q)
   );

   cfg_commit u_commit (
      .clk(clk), .rst_n(rst_n),
      .strobe_in(cfg_q[STB_BIT]), .commit(phy_cfg_we)
   );

   assign phy_cfg_addr = cfg_q[CADDR_LSB +: CADDR_W];
   assign phy_cfg_data = cfg_q[CDATA_LSB +: CDATA_W];

   phy_cfg_store #(.AW(CADDR_W), .DW(CDATA_W), .CLEAR_ON_RESET(1'b1)) u_store (
      .clk(clk), .rst_n(rst_n), .we(phy_cfg_we),
      .waddr(phy_cfg_addr), .wdata(phy_cfg_data),
      .raddr(store_raddr), .rdata(store_rdata)
   );

   assign lane_idle = lane_q[LANE_LSB +: LANES];

   always_comb begin
      stat_w = '0;
      stat_w[STAT_LOCK_BIT] = pll_locked;
      stat_w[STAT_PEND_BIT] = pll_out_pend;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(REG_CFG):  bus_rdata[HALF-1:0] = cfg_q;
         ADDR_W'(REG_LANE): bus_rdata[HALF-1:0] = lane_q;
         ADDR_W'(REG_STAT): bus_rdata[HALF-1:0] = stat_w;
         default:           bus_rdata = '0;
      endcase
   end

   AST_RISE_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cfg && wr_mask[STB_BIT] && wr_val[STB_BIT] && !cfg_q[STB_BIT])
      |=> phy_cfg_we); // R3
   AST_HELD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[STB_BIT] && $past(cfg_q[STB_BIT])) |-> !phy_cfg_we); // R3
   AST_EMPTY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && wr_mask == '0)
      |=> (cfg_q == $past(cfg_q) && lane_q == $past(lane_q))); // R8
endmodule

// File: tb/wmask_cfg_bank_test.sv
module wmask_cfg_bank_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pll_locked = 1'b0;
   logic        pll_out_pend = 1'b0;
   logic [3:0]  lane_idle;
   logic        phy_cfg_we;
   logic [5:0]  phy_cfg_addr;
   logic [3:0]  phy_cfg_data;
   logic [5:0]  store_raddr = '0;
   logic [3:0]  store_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] exp_cfg;
   logic [15:0] exp_lane;
   logic [3:0]  exp_store [64];

   wmask_cfg_bank uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pll_locked(pll_locked), .pll_out_pend(pll_out_pend),
      .lane_idle(lane_idle), .phy_cfg_we(phy_cfg_we),
      .phy_cfg_addr(phy_cfg_addr), .phy_cfg_data(phy_cfg_data),
      .store_raddr(store_raddr), .store_rdata(store_rdata)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [15:0] masked(input logic [15:0] old, input logic [31:0] w);
      return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
   endfunction

   function automatic logic [31:0] exp_read(input logic [1:0] a);
      logic [31:0] r;
      r = '0;
      case (a)
         2'd0: r[15:0] = exp_cfg;
         2'd1: r[15:0] = exp_lane;
         2'd2: begin r[9] = pll_locked; r[10] = pll_out_pend; end
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Reads every register index and the lane outputs; R1 R2 R5 R6
   task automatic check_regs(input string req);
      for (int a = 0; a < 4; a++) begin
         bus_addr = a[1:0];
         #1;
         check(req, bus_rdata, exp_read(a[1:0]));
      end
      check("R5 lane_idle", {28'd0, lane_idle}, {28'd0, exp_lane[6:3]});
   endtask

   task automatic do_write(input logic [1:0] a, input logic [31:0] w);
      logic       rise;
      logic [5:0] ca;
      logic [3:0] cd;
      logic [15:0] nv;
      rise = 1'b0;
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = w;
      if (a == 2'd0) begin
         nv = masked(exp_cfg, w);
         rise = !exp_cfg[0] && nv[0];
         exp_cfg = nv;
      end else if (a == 2'd1) begin
         exp_lane = masked(exp_lane, w);
      end
      ca = exp_cfg[6:1];
      cd = exp_cfg[10:7];
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
      if (w[31:16] == 16'h0)
         check("R8 no commit on empty mask", {31'd0, phy_cfg_we}, {31'd0, rise});
      else
         check("R3 commit pulse", {31'd0, phy_cfg_we}, {31'd0, rise});
      if (rise) begin
         check("R9 commit address", {26'd0, phy_cfg_addr}, {26'd0, ca});
         check("R9 commit data", {28'd0, phy_cfg_data}, {28'd0, cd});
         exp_store[ca] = cd;
      end
      @(negedge clk);
      check("R3 pulse is single", {31'd0, phy_cfg_we}, 32'd0);
      if (rise) begin
         store_raddr = ca;
         #1;
         check("R4 store entry", {28'd0, store_rdata}, {28'd0, exp_store[ca]});
      end
      check_regs("R1 R2 R6 register contents");
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5eed_1234));
      exp_cfg = '0;
      exp_lane = 16'h0078;
      for (int i = 0; i < 64; i++) exp_store[i] = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: reset state
      check_regs("R7 reset registers");
      check("R7 no pulse after reset", {31'd0, phy_cfg_we}, 32'd0);
      store_raddr = 6'd0;  #1; check("R7 store entry 0", {28'd0, store_rdata}, 32'd0);
      store_raddr = 6'd63; #1; check("R7 store entry 63", {28'd0, store_rdata}, 32'd0);

      // R3 R4: three-step sequence to address 0x2a, data 0x9
      do_write(2'd0, {16'h07FE, 16'((4'h9 << 7) | (6'h2a << 1))});
      do_write(2'd0, 32'h0001_0001);
      do_write(2'd0, 32'h0001_0001);   // strobe already 1: no commit
      do_write(2'd0, 32'h0001_0000);   // clear strobe
      // fields and strobe raised in one word: address 0x3f, data 0x5
      do_write(2'd0, {16'h07FF, 16'((4'h5 << 7) | (6'h3f << 1) | 1)});
      // R8: empty mask with data that would clear the strobe
      do_write(2'd0, 32'h0000_0000);
      do_write(2'd1, 32'h0000_FFFF);
      // R1: partial mask on lane register releases lanes 1 and 3 only
      do_write(2'd1, 32'h0050_0000);
      // R6: write to status has no effect
      pll_locked = 1'b1; pll_out_pend = 1'b1;
      do_write(2'd2, 32'hFFFF_FFFF);
      pll_out_pend = 1'b0;
      do_write(2'd3, 32'hFFFF_FFFF);

      // Constrained random traffic
      for (int n = 0; n < 400; n++) begin
         logic [1:0]  a;
         logic [31:0] w;
         a = 2'($urandom_range(0, 3));
         w = $urandom;
         if ($urandom_range(0, 7) == 0) w[31:16] = 16'h0;
         if (a == 2'd0 && $urandom_range(0, 1) == 1) w[16] = 1'b1;
         pll_locked = 1'($urandom);
         pll_out_pend = 1'($urandom);
         do_write(a, w);
      end

      // Final sweep of the store against the model; R4
      for (int i = 0; i < 64; i++) begin
         store_raddr = i[5:0];
         #1;
         check("R4 store sweep", {28'd0, store_rdata}, {28'd0, exp_store[i]});
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule